// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Page-Write Sequencer

This block is the device-side control logic of a byte-wide nonvolatile memory, running on a system clock. It samples three active-low strobes (chip select, write strobe, output enable), a 16-bit address and an 8-bit data input on each rising clock edge. Write cycles are collected into a page buffer of up to 128 bytes. All bytes in one page operation share address bits 15 to 7. Each new load must start within a byte-load timeout of the previous accepted load. There is no limit on the total length of the page window.

When the timeout runs out with no write in progress, a self-timed programming phase begins. Its length is a fixed number of clock cycles. During that phase only the loaded bytes are copied into a small on-chip array. Any read during programming returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the last loaded byte. Bit 6 alternates on every read access, and bits 5 to 0 are zero. After the phase ends, reads return the array contents again.

Top module: `eeprom_page_seq`

## Requirements
- R1: `dout_oe` is 1 two clock edges after an edge that sampled `ce_n` and `oe_n` both low. It is 0 whenever the strobes sampled at that edge had either `ce_n` or `oe_n` high.
- R2: A write cycle is active while `ce_n` and `we_n` are low and `oe_n` is high. Either `ce_n` or `we_n` may be the strobe that opens and closes the cycle. After programming, a read of the written address returns the written byte.
- R3: The address is taken at the first edge where the write cycle is active, which is the later of the two falling strobes. Address changes before that edge or later in the same cycle have no effect.
- R4: The stored data is `din` as sampled at the last edge where the write cycle was still active. A change of `din` that arrives together with the first rising strobe is not stored.
- R5: The first load of an operation fixes the page, which is address bits 15:7. A later load whose bits 15:7 differ, in any bit, is ignored and leaves the array unchanged.
- R6: A load that starts within `T_LOAD` cycles of the previous accepted load joins the same page. Any number of such loads may follow one another. Programming begins on the first edge, `T_LOAD` or more cycles after the last accepted load start, at which no write cycle is active.
- R7: Programming lasts `T_PROG` cycles. It writes only the loaded offsets of the page. Every other array byte keeps its value.
- R8: During programming, every read returns the status byte, whatever the address. Its bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5:0 are zero.
- R9: Bit 6 of the status byte inverts on every new read access during programming, and the first read of a phase returns 1. Once programming has ended, reads return array data.
- R10: Write cycles that start during programming are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Byte address; bits 15:7 select the page |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or status byte |
| dout_oe | output | 1 | Registered drive enable for `dout`; 0 means the bus is released |

## Verification
The bench builds the block with `ARRAY_AW=9`, `T_LOAD=16` and `T_PROG=160`. With these values the array is four pages, and every byte of it can be written and read back. The short load timeout lets a test chain long runs of loads, each just inside the window, and still finish quickly. The programming phase is long enough to hold several status reads and an ignored write attempt. This is how the toggle sequence and the inverted bit 7 are checked before the array is read back.

// File: rtl/esp_pkg.sv
package esp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } esp_state_e;
endpackage

// File: rtl/esp_bus_if.sv
// Strobe decoder: write/read windows, their edges, address and data capture.
module esp_bus_if #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_act,
  output logic              wr_start,
  output logic              wr_end,
  output logic              rd_act,
  output logic              rd_start,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  logic wr_q, rd_q;

  assign wr_act   = !ce_n && !we_n && oe_n;
  assign rd_act   = !ce_n && !oe_n;
  assign wr_start = wr_act && !wr_q;
  assign wr_end   = !wr_act && wr_q;
  assign rd_start = rd_act && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_start) cap_addr <= addr;
      // data follows the bus while the window is open; the last value stays
      if (wr_act) cap_data <= din;
    end
  end
endmodule

// File: rtl/esp_page_buf.sv
// Page staging buffer with one valid flag per byte offset.
module esp_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [OFS_W-1:0]       waddr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   clr,
  input  logic [OFS_W-1:0]       ridx,
  output logic [DATA_W-1:0]      rdata,
  output logic [(1<<OFS_W)-1:0]  vld
);
  localparam int PAGE_BYTES = 1 << OFS_W;

  logic [DATA_W-1:0] mem [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[waddr] <= 1'b1;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/esp_array.sv
// Simple dual-port synchronous array, shaped for block-RAM inference.
module esp_array #(
  parameter int AW     = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/esp_ctrl.sv
// Sequencer: page open/load, byte-load timeout, programming sweep, toggle bit.
module esp_ctrl
  import esp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 7,
  parameter int ARRAY_AW = 10,
  parameter int T_LOAD   = 20000,
  parameter int T_PROG   = 1000000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_act,
  input  logic                  wr_start,
  input  logic                  wr_end,
  input  logic                  rd_start,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [ADDR_W-1:0]     cap_addr,
  input  logic [DATA_W-1:0]     cap_data,
  input  logic [(1<<OFS_W)-1:0] buf_vld,
  input  logic [DATA_W-1:0]     buf_rdata,
  output logic                  busy,
  output logic                  tog,
  output logic                  last_msb,
  output logic                  buf_we,
  output logic [OFS_W-1:0]      buf_waddr,
  output logic [DATA_W-1:0]     buf_wdata,
  output logic [OFS_W-1:0]      buf_ridx,
  output logic                  buf_clr,
  output logic                  mem_we,
  output logic [ARRAY_AW-1:0]   mem_waddr,
  output logic [DATA_W-1:0]     mem_wdata
);
  localparam int PG_W       = ADDR_W - OFS_W;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int TL_W       = $clog2(T_LOAD + 1);
  localparam int TP_W       = $clog2(T_PROG + PAGE_BYTES + 1);
  localparam logic [TL_W-1:0] TL_END = TL_W'(T_LOAD);
  localparam logic [TP_W-1:0] TP_END = TP_W'(T_PROG - 1);

  esp_state_e      st;
  logic [PG_W-1:0] page_q;
  logic            ld_open;
  logic [TL_W-1:0] tmr;
  logic [TP_W-1:0] pcnt;
  logic            page_match;
  logic [ADDR_W-1:0] full_waddr;

  assign page_match = (addr[ADDR_W-1:OFS_W] == page_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      page_q   <= '0;
      ld_open  <= 1'b0;
      tmr      <= '0;
      pcnt     <= '0;
      tog      <= 1'b0;
      last_msb <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (wr_start) begin
            st      <= ST_LOAD;
            page_q  <= addr[ADDR_W-1:OFS_W];
            ld_open <= 1'b1;
            tmr     <= '0;
          end
        end
        ST_LOAD: begin
          if (wr_start && page_match) tmr <= '0;
          else if (tmr != TL_END)     tmr <= tmr + 1'b1;
          if (wr_start) ld_open <= page_match;
          if (wr_end) begin
            ld_open <= 1'b0;
            if (ld_open) last_msb <= cap_data[DATA_W-1];
          end
          if (tmr == TL_END && !wr_act) begin
            st   <= ST_PROG;
            pcnt <= '0;
            tog  <= 1'b0;
          end
        end
        default: begin
          ld_open <= 1'b0;
          if (rd_start) tog <= ~tog;
          if (pcnt == TP_END) st <= ST_IDLE;
          else                pcnt <= pcnt + 1'b1;
        end
      endcase
    end
  end

  assign busy      = (st == ST_PROG);
  assign buf_we    = (st == ST_LOAD) && wr_end && ld_open;
  assign buf_waddr = cap_addr[OFS_W-1:0];
  assign buf_wdata = cap_data;
  assign buf_clr   = busy && (pcnt == TP_END);

  // programming sweep: one offset per cycle over the first PAGE_BYTES cycles
  assign buf_ridx   = pcnt[OFS_W-1:0];
  assign full_waddr = {page_q, pcnt[OFS_W-1:0]};
  assign mem_waddr  = full_waddr[ARRAY_AW-1:0];
  assign mem_wdata  = buf_rdata;
  assign mem_we     = busy && (pcnt < TP_W'(PAGE_BYTES)) && buf_vld[pcnt[OFS_W-1:0]];
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 7,
  parameter int ARRAY_AW = 10,
  parameter int T_LOAD   = 20000,
  parameter int T_PROG   = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int PAGE_BYTES = 1 << OFS_W;

  logic wr_act, wr_start, wr_end, rd_act, rd_start;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic busy, tog, last_msb;
  logic buf_we, buf_clr, mem_we;
  logic [OFS_W-1:0] buf_waddr, buf_ridx;
  logic [DATA_W-1:0] buf_wdata, buf_rdata, mem_wdata, mem_q;
  logic [PAGE_BYTES-1:0] buf_vld;
  logic [ARRAY_AW-1:0] mem_waddr;
  logic rd_q1;
  logic [DATA_W-1:0] status;

  esp_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_act(wr_act), .wr_start(wr_start),
    .wr_end(wr_end), .rd_act(rd_act), .rd_start(rd_start),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  esp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
    .ARRAY_AW(ARRAY_AW), .T_LOAD(T_LOAD), .T_PROG(T_PROG)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_act(wr_act), .wr_start(wr_start),
    .wr_end(wr_end), .rd_start(rd_start), .addr(addr),
    .cap_addr(cap_addr), .cap_data(cap_data), .buf_vld(buf_vld),
    .buf_rdata(buf_rdata), .busy(busy), .tog(tog), .last_msb(last_msb),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_ridx(buf_ridx), .buf_clr(buf_clr), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  esp_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .waddr(buf_waddr),
    .wdata(buf_wdata), .clr(buf_clr), .ridx(buf_ridx),
    .rdata(buf_rdata), .vld(buf_vld)
  );

  esp_array #(.AW(ARRAY_AW), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr[ARRAY_AW-1:0]), .q(mem_q)
  );

  assign status = {~last_msb, tog, {(DATA_W-2){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q1   <= 1'b0;
      dout_oe <= 1'b0;
      dout    <= '0;
    end else begin
      rd_q1   <= rd_act;
      dout_oe <= rd_q1;
      dout    <= busy ? status : mem_q;
    end
  end
endmodule

// File: rtl/esp_page_seq_chk.sv
module esp_page_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              dout_oe,
  input logic [DATA_W-1:0] dout,
  input logic              busy,
  input logic              tog,
  input logic              mem_we,
  input logic              buf_we
);
  p_drive_only_on_read_r1: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(!ce_n && !oe_n, 2));

  p_array_write_in_prog_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_no_load_in_prog_r10: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !busy);

  p_status_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(busy)) |-> (dout[DATA_W-3:0] == '0));

  p_toggle_starts_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tog);
endmodule

bind eeprom_page_seq esp_page_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .dout_oe(dout_oe),
  .dout(dout), .busy(busy), .tog(tog), .mem_we(mem_we), .buf_we(buf_we)
);

// File: tb/tb_eeprom_page_seq.sv
module tb_eeprom_page_seq;
  localparam int TL = 16;
  localparam int TP = 160;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [512];

  always #2.5 clk = ~clk;

  eeprom_page_seq #(.ARRAY_AW(AW), .T_LOAD(TL), .T_PROG(TP)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt * 11 + 5) ^ (a >> 3));
  endfunction

  // one read access; returns {oe, data}
  task automatic rd(input logic [15:0] a, output logic [8:0] r);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    tick(2);
    r = {dout_oe, dout};
    ce_n = 1'b1; oe_n = 1'b1;
    tick(1);
  endtask

  // write-strobe controlled cycle; din changes together with the rising strobe
  task automatic wr_we(input logic [15:0] a, input logic [7:0] d, input bit acc);
    oe_n = 1'b1; addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    tick(2);
    we_n = 1'b1; din = ~d;
    tick(1);
    ce_n = 1'b1;
    tick(1);
    if (acc) model[a[8:0]] = d;
  endtask

  // chip-select controlled cycle; address is wrong until the later strobe falls
  task automatic wr_ce(input logic [15:0] a, input logic [7:0] d, input bit acc);
    oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1; addr = a ^ 16'h0055; din = d;
    tick(1);
    addr = a; ce_n = 1'b0;
    tick(2);
    ce_n = 1'b1; din = ~d;
    tick(1);
    we_n = 1'b1;
    tick(1);
    if (acc) model[a[8:0]] = d;
  endtask

  task automatic wait_prog();
    tick(TL + TP + 8);
  endtask

  task automatic check_mem(input string req, input int a);
    logic [8:0] r;
    rd(16'(a), r);
    check(req, int'(r), int'({1'b1, model[a]}));
  endtask

  logic done = 1'b0;

  initial begin
    logic [8:0] r;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state, bus released
    check("R1 reset", int'(dout_oe), 0);

    // R2/R3/R4: fill all four pages, alternating strobe control
    for (int pg = 0; pg < 4; pg++) begin
      for (int o = 0; o < 128; o++) begin
        if (pg % 2 == 0) wr_we(16'(pg * 128 + o), pat(pg * 128 + o, 1), 1'b1);
        else             wr_ce(16'(pg * 128 + o), pat(pg * 128 + o, 1), 1'b1);
      end
      wait_prog();
    end
    for (int a = 0; a < 512; a++) check_mem("R2 full sweep", a);

    // R1: bus released when one of the two enables is high
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; tick(3);
    check("R1 oe high", int'(dout_oe), 0);
    ce_n = 1'b1; oe_n = 1'b0; tick(3);
    check("R1 ce high", int'(dout_oe), 0);
    oe_n = 1'b1; tick(2);

    // R5/R7: partial page 1 plus a foreign-page load that must be ignored
    wr_we(16'(128 + 2),   8'h3C, 1'b1);
    wr_we(16'h8100 | 16'd9, 8'hE7, 1'b0); // bits 15:7 differ, aliases page 2
    wr_ce(16'(128 + 127), 8'h81, 1'b1);
    wr_we(16'(128 + 9),   8'h4B, 1'b1);
    wait_prog();
    for (int o = 0; o < 128; o++) check_mem("R7 partial page", 128 + o);
    for (int o = 0; o < 16; o++)  check_mem("R5 foreign page ignored", 256 + o);

    // R3: address change inside an open write cycle is ignored
    oe_n = 1'b1; addr = 16'(384 + 10); din = 8'h6D; ce_n = 1'b0; we_n = 1'b0;
    tick(1);
    addr = 16'(384 + 11);
    tick(1);
    we_n = 1'b1; tick(1); ce_n = 1'b1; tick(1);
    model[384 + 10] = 8'h6D;
    wait_prog();
    check_mem("R3 address at opening edge", 384 + 10);
    check_mem("R3 later address unused", 384 + 11);

    // R8/R9/R10: status reads and an ignored write during programming
    wr_we(16'd5, 8'h5A, 1'b1);
    tick(TL + 4);
    rd(16'd300, r); check("R9 first status read", int'(r), 9'h1C0);
    rd(16'd5, r);   check("R9 second status read", int'(r), 9'h180);
    wr_we(16'd6, 8'h11, 1'b0);
    rd(16'd6, r);   check("R8 R9 third status read", int'(r), 9'h1C0);
    wait_prog();
    check_mem("R9 true data after programming", 5);
    check_mem("R10 write during programming ignored", 6);

    wr_ce(16'(128 + 7), 8'hA5, 1'b1);
    tick(TL + 4);
    rd(16'd450, r); check("R8 inverted bit7 any address", int'(r), 9'h140);
    wait_prog();
    check_mem("R8 committed byte", 128 + 7);

    // R6: long chain of loads, each inside the timeout window
    for (int k = 0; k < 20; k++) begin
      wr_we(16'(256 + 40 + k), pat(k, 7), 1'b1);
      tick(TL / 2);
    end
    wait_prog();
    for (int k = 0; k < 20; k++) check_mem("R6 open-ended window", 256 + 40 + k);
    check_mem("R6 neighbour unchanged", 256 + 39);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule